// File: doc/BRIEF.md
# Byte-Wide SPI Port with Prescaled Clock

This block is a full-duplex SPI port that moves one byte per transfer, most significant bit first. It works as a master or as a slave. As a master it drives the serial clock from the system clock through a divider. The divide ratio is chosen by a two-bit rate field and a double-speed bit. As a slave it follows an external serial clock and an active-low select. The clock polarity and clock phase inputs set the idle level and choose which edge samples data and which edge sets it up.

Software gives the block level-style control inputs. A write strobe loads the transmit byte; in master mode it also starts the transfer. The received byte can be read at any time. A completion flag is raised when a byte finishes, and an interrupt request follows from that flag. The flag is cleared by an interrupt-acknowledge pulse, or by a status read followed by a data access.

If the select input goes low while the port is master, another master has claimed the bus. The port drops back to slave mode and raises the completion flag. It stays a slave until software selects master mode again.

Top module: `spi_port`

## Requirements
- R1: After reset, done_o, wcol_o, mstr_o and irq_o are 0. sck_oe_o, mosi_oe_o and miso_oe_o are 0.
- R2: When the port is master and no transfer is running, sck_o equals cpol_i: high when cpol_i=1 and low when cpol_i=0.
- R3: In master mode the SCK period, in system clocks, is set by {dbl_i, rate_i}: 000→4, 001→16, 010→64, 011→128, 100→2, 101→8, 110→32, 111→64.
- R4: The leading SCK edge is the one that leaves the idle level (rising when cpol_i=0). With cpha_i=0, data is sampled on leading edges and set up on trailing edges. With cpha_i=1, data is set up on leading edges and sampled on trailing edges.
- R5: Bytes shift MSB first and full-duplex. After a transfer, rx_data_o holds the 8 bits received and the peer holds the 8 bits that were loaded.
- R6: done_o rises when the 8th bit of a byte is sampled. irq_o is high exactly when done_o, irq_en_i and gie_i are all high.
- R7: A pulse on irq_ack_i clears done_o.
- R8: A stat_rd_i pulse taken while done_o or wcol_o is set arms a clear. The next data_rd_i or data_we_i pulse then clears both flags. A data access with no armed clear does not clear them.
- R9: A data_we_i pulse while the port is busy is ignored and sets wcol_o. Busy means a master transfer is running, or the port is a slave and ss_ni is low.
- R10: While enabled as master, a low level on ss_ni sets done_o and clears mstr_o and sck_oe_o. The port stays slave after ss_ni returns high, until mstr_we_i loads mstr_i=1.
- R11: As a slave with cpha_i=0, the top bit of the shift register is driven on miso_o after ss_ni falls, before any SCK edge.
- R12: rate_i and dbl_i have no effect on slave transfers.
- R13: miso_oe_o is high only when the port is an enabled slave and ss_ni is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable |
| mstr_we_i | input | 1 | Strobe that loads the master/slave selection |
| mstr_i | input | 1 | Mode value loaded by mstr_we_i: 1 = master |
| cpol_i | input | 1 | Clock polarity (idle level of SCK) |
| cpha_i | input | 1 | Clock phase: 0 = sample on leading edge, 1 = sample on trailing edge |
| rate_i | input | 2 | Master SCK rate select |
| dbl_i | input | 1 | Double-speed select |
| irq_en_i | input | 1 | Interrupt enable for this port |
| gie_i | input | 1 | Global interrupt enable |
| data_we_i | input | 1 | Data write strobe |
| data_i | input | 8 | Transmit byte |
| data_rd_i | input | 1 | Data read strobe (used only for flag clearing) |
| stat_rd_i | input | 1 | Status read strobe |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| rx_data_o | output | 8 | Last received byte |
| done_o | output | 1 | Transfer-complete flag |
| wcol_o | output | 1 | Write-collision flag |
| mstr_o | output | 1 | Current mode: 1 = master |
| irq_o | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_oe_o | output | 1 | MOSI output enable |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe_o | output | 1 | MISO output enable |
| ss_ni | input | 1 | Active-low select input |

## Verification
A bit counter that is off by one shows in two ways. done_o rises one SCK edge early or late, and the byte caught by the peer or by rx_data_o is rotated by one bit. Both are visible at the end of the first byte. A divider fault changes the measured SCK period within the first two leading edges. A phase mix-up corrupts every bit after the first. A stale mode register shows on mstr_o and sck_oe_o within two clocks of the select falling, and it stays there after the select is released.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int unsigned LG_W = 3;

  // log2 of the half SCK period in system clocks
  function automatic logic [LG_W-1:0] half_log2(input logic dbl, input logic [1:0] rate);
    logic [LG_W-1:0] base;
    base = (rate == 2'd3) ? LG_W'(6) : {rate, 1'b1};
    return base - LG_W'(dbl);
  endfunction
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_port_pkg::*;
#(
  parameter int unsigned MAX_LG = 6,
  localparam int unsigned CNT_W = MAX_LG
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       dbl_i,
  input  logic [1:0] rate_i,
  output logic       tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   span;
  logic [LG_W-1:0]  lg;

  assign lg     = half_log2(dbl_i, rate_i);
  assign span   = ({{CNT_W{1'b0}}, 1'b1} << lg) - 1'b1;
  assign tick_o = run_i && (cnt_q == span[CNT_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || tick_o)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && lg != '0) |=> !tick_o);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int unsigned W = 8,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  input  logic         shift_i,
  input  logic         setup_i,
  input  logic         prime_i,
  input  logic         clr_i,
  input  logic         in_i,
  output logic         out_o,
  output logic         done_o,
  output logic [W-1:0] rx_o
);
  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = shift_i && !load_i && (cnt_q == CW'(W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      out_o  <= 1'b0;
      rx_o   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last;
      if (load_i) begin
        sh_q  <= din_i;
        out_o <= din_i[W-1];
        cnt_q <= '0;
      end else begin
        if (clr_i) cnt_q <= '0;
        if (shift_i) begin
          sh_q  <= {sh_q[W-2:0], in_i};
          cnt_q <= last ? '0 : cnt_q + 1'b1;
          if (last) rx_o <= {sh_q[W-2:0], in_i};
        end
        if (setup_i || prime_i) out_o <= sh_q[W-1];
      end
    end
  end

  // R5
  sh_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(sh_q));
  // R5
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last |=> $stable(rx_o));
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MAX_LG = 6,
  localparam int unsigned EDGES = 2 * DATA_W,
  localparam int unsigned EW = $clog2(EDGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              mstr_we_i,
  input  logic              mstr_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [1:0]        rate_i,
  input  logic              dbl_i,
  input  logic              irq_en_i,
  input  logic              gie_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              data_rd_i,
  input  logic              stat_rd_i,
  input  logic              irq_ack_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              done_o,
  output logic              wcol_o,
  output logic              mstr_o,
  output logic              irq_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              ss_ni
);
  logic [1:0] sck_sy, mosi_sy, ss_sy;
  logic       sck_d, ss_d, sck_s, mosi_s, ss_s;
  logic       mstr_q, m_busy, sck_ph, done_q, wcol_q, arm_q;
  logic [EW-1:0] e_cnt;
  logic tick, fault, busy, wr_ok, start, collide, set_done, clr_acc;
  logic slave_act, s_edge, s_lead, s_trail, lead, trail, shift, setup, prime;
  logic core_out, core_done, in_bit;

  assign sck_s  = sck_sy[1];
  assign mosi_s = mosi_sy[1];
  assign ss_s   = ss_sy[1];

  // 2-flop sync of slave-side pins, plus edge history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sy <= '0; mosi_sy <= '0; ss_sy <= '1;
      sck_d  <= 1'b0; ss_d <= 1'b1;
    end else begin
      sck_sy  <= {sck_sy[0], sck_i};
      mosi_sy <= {mosi_sy[0], mosi_i};
      ss_sy   <= {ss_sy[0], ss_ni};
      sck_d   <= sck_s;
      ss_d    <= ss_s;
    end
  end

  assign fault     = en_i && mstr_q && !ss_s;
  assign slave_act = en_i && !mstr_q && !ss_s;
  assign busy      = mstr_q ? m_busy : slave_act;
  assign wr_ok     = data_we_i && !busy;
  assign collide   = data_we_i && busy;
  assign start     = wr_ok && en_i && mstr_q && !fault;

  spi_rate_gen #(.MAX_LG(MAX_LG)) u_rate (
    .clk_i, .rst_ni, .run_i(m_busy), .dbl_i, .rate_i, .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mstr_q <= 1'b0; m_busy <= 1'b0; sck_ph <= 1'b0; e_cnt <= '0;
    end else begin
      if (fault)          mstr_q <= 1'b0;
      else if (mstr_we_i) mstr_q <= mstr_i;
      if (fault) begin
        m_busy <= 1'b0; sck_ph <= 1'b0; e_cnt <= '0;
      end else if (start) begin
        m_busy <= 1'b1; sck_ph <= 1'b0; e_cnt <= '0;
      end else if (tick) begin
        sck_ph <= ~sck_ph;
        e_cnt  <= e_cnt + 1'b1;
        if (e_cnt == EW'(EDGES-1)) m_busy <= 1'b0;
      end
    end
  end

  // leading edge leaves the idle level
  assign s_edge  = slave_act && (sck_s ^ sck_d);
  assign s_lead  = s_edge && (sck_d == cpol_i);
  assign s_trail = s_edge && (sck_d != cpol_i);
  assign lead    = mstr_q ? (tick && !e_cnt[0]) : s_lead;
  assign trail   = mstr_q ? (tick &&  e_cnt[0]) : s_trail;
  assign shift   = cpha_i ? trail : lead;
  assign setup   = cpha_i ? lead : trail;
  assign prime   = slave_act && !cpha_i && ss_d;
  assign in_bit  = mstr_q ? miso_i : mosi_s;

  spi_shift_core #(.W(DATA_W)) u_core (
    .clk_i, .rst_ni, .load_i(wr_ok), .din_i(data_i), .shift_i(shift),
    .setup_i(setup), .prime_i(prime), .clr_i(!mstr_q && ss_s), .in_i(in_bit),
    .out_o(core_out), .done_o(core_done), .rx_o(rx_data_o)
  );

  assign set_done = core_done || fault;
  assign clr_acc  = arm_q && (data_rd_i || data_we_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0; wcol_q <= 1'b0; arm_q <= 1'b0;
    end else begin
      if (set_done)                    done_q <= 1'b1;
      else if (irq_ack_i || clr_acc)   done_q <= 1'b0;
      if (collide)                     wcol_q <= 1'b1;
      else if (clr_acc)                wcol_q <= 1'b0;
      if (clr_acc)                     arm_q <= 1'b0;
      else if (stat_rd_i && (done_q || wcol_q)) arm_q <= 1'b1;
    end
  end

  assign done_o    = done_q;
  assign wcol_o    = wcol_q;
  assign mstr_o    = mstr_q;
  assign irq_o     = done_q && irq_en_i && gie_i;
  assign sck_o     = cpol_i ^ sck_ph;
  assign sck_oe_o  = en_i && mstr_q;
  assign mosi_o    = core_out;
  assign mosi_oe_o = en_i && mstr_q;
  assign miso_o    = core_out;
  assign miso_oe_o = slave_act;

  // R10
  fault_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mstr_q && !ss_s) |=> (!mstr_q && done_q));
  // R9
  wcol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && busy) |=> wcol_q);
  // R7
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !set_done) |=> !done_q);
  // R2
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mstr_q && !m_busy) |-> (sck_ph == 1'b0));
endmodule

// File: tb/sim_spi_port.sv
module sim_spi_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, mstr_we = 0, mstr = 0, cpol = 0, cpha = 0, dbl = 0;
  logic [1:0] rate = 0;
  logic irq_en = 0, gie = 0, data_we = 0, data_rd = 0, stat_rd = 0, irq_ack = 0;
  logic [7:0] data = 0, rx_data;
  logic done, wcol, mstr_st, irq;
  logic sck_i = 0, mosi_i = 0, miso_i = 0, ss_n = 1;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  int n_cmp = 0, n_bad = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  spi_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mstr_we_i(mstr_we), .mstr_i(mstr),
    .cpol_i(cpol), .cpha_i(cpha), .rate_i(rate), .dbl_i(dbl), .irq_en_i(irq_en),
    .gie_i(gie), .data_we_i(data_we), .data_i(data), .data_rd_i(data_rd),
    .stat_rd_i(stat_rd), .irq_ack_i(irq_ack), .rx_data_o(rx_data), .done_o(done),
    .wcol_o(wcol), .mstr_o(mstr_st), .irq_o(irq), .sck_i(sck_i), .sck_o(sck_o),
    .sck_oe_o(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe_o(miso_oe), .ss_ni(ss_n)
  );

  // peer slave model for master tests
  logic [7:0] bs_buf = 0, bs_tx = 0;
  logic bs_arm = 0, bs_first = 1, mon_prev = 0, lead_e;
  int cyc = 0, last_lead = 0, per = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (bs_arm) begin
      bs_buf = bs_tx; miso_i = bs_tx[7]; bs_first = 1; mon_prev = sck_o; per = 0;
    end else if (sck_o !== mon_prev) begin
      lead_e = (mon_prev == cpol);
      if (lead_e) begin
        if (!bs_first) per = cyc - last_lead;
        last_lead = cyc; bs_first = 0;
      end
      if (lead_e ^ cpha) bs_buf = {bs_buf[6:0], mosi_o};
      else               miso_i = bs_buf[7];
      mon_prev = sck_o;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic tick_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(logic [7:0] b);
    @(negedge clk); data = b; data_we = 1;
    @(negedge clk); data_we = 0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
  endtask

  task automatic set_mode(logic m);
    @(negedge clk); mstr = m; mstr_we = 1; @(negedge clk); mstr_we = 0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 4000 && !done; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 done", done, 0);
    chk("R1 wcol", wcol, 0);
    chk("R1 mstr", mstr_st, 0);
    chk("R1 irq", irq, 0);
    chk("R1 oe", {sck_oe, mosi_oe, miso_oe}, 0);
  endtask

  // master transfer against the peer model
  task automatic m_xfer(logic p, logic h, logic d, logic [1:0] r,
                        logic [7:0] tx, logic [7:0] ptx, int ratio);
    @(negedge clk); cpol = p; cpha = h; dbl = d; rate = r; en = 1;
    set_mode(1);
    tick_n(2);
    chk("R2 idle", sck_o, p);
    @(posedge clk); bs_tx = ptx; bs_arm = 1;
    @(posedge clk); bs_arm = 0;
    wr_byte(tx);
    wait_done();
    chk("R6 done", done, 1);
    chk("R5 rx", rx_data, ptx);
    chk("R4 peer", bs_buf, tx);
    chk("R3 period", per, ratio);
    tick_n(ratio + 2);
    chk("R2 back idle", sck_o, p);
    pulse_ack();
  endtask

  // slave transfer driven by the bench as master
  task automatic s_xfer(logic p, logic h, logic do_load, logic [7:0] tx,
                        logic [7:0] mtx, logic [7:0] exp_cap, string tag);
    logic [7:0] cap;
    cap = 0;
    set_mode(0);
    @(negedge clk); cpol = p; cpha = h; en = 1; sck_i = p;
    if (do_load) wr_byte(tx);
    tick_n(4);
    chk("R13 oe idle", miso_oe, 0);
    @(negedge clk); ss_n = 0;
    tick_n(6);
    chk("R13 oe sel", miso_oe, 1);
    if (!h) chk("R11 first bit", miso_o, exp_cap[7]);
    for (int i = 7; i >= 0; i--) begin
      if (!h) begin
        mosi_i = mtx[i]; tick_n(8);
        sck_i = ~p; cap[i] = miso_o; tick_n(8);
        sck_i = p;
      end else begin
        sck_i = ~p; tick_n(2); mosi_i = mtx[i]; tick_n(6);
        sck_i = p; cap[i] = miso_o; tick_n(8);
      end
    end
    tick_n(6);
    chk({tag, " done"}, done, 1);
    chk({tag, " rx"}, rx_data, mtx);
    chk({tag, " miso"}, cap, exp_cap);
    @(negedge clk); ss_n = 1;
    tick_n(4);
    pulse_ack();
  endtask

  task automatic t_collide();
    @(negedge clk); cpol = 0; cpha = 0; dbl = 0; rate = 2'd1; en = 1;
    set_mode(1);
    @(posedge clk); bs_tx = 8'h0F; bs_arm = 1;
    @(posedge clk); bs_arm = 0;
    wr_byte(8'hC3);
    tick_n(20);
    wr_byte(8'h55);
    chk("R9 wcol set", wcol, 1);
    wait_done();
    chk("R9 write ignored", bs_buf, 8'hC3);
    @(negedge clk); data_rd = 1; @(negedge clk); data_rd = 0;
    chk("R8 no arm keeps done", done, 1);
    @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0;
    tick_n(2);
    chk("R8 status only keeps wcol", wcol, 1);
    @(negedge clk); data_rd = 1; @(negedge clk); data_rd = 0;
    chk("R8 clear done", done, 0);
    chk("R8 clear wcol", wcol, 0);
  endtask

  task automatic t_irq();
    @(negedge clk); irq_en = 1; gie = 0;
    @(negedge clk); cpol = 1; cpha = 1; dbl = 1; rate = 0;
    @(posedge clk); bs_tx = 8'h81; bs_arm = 1;
    @(posedge clk); bs_arm = 0;
    wr_byte(8'h7E);
    wait_done();
    chk("R6 gated irq", irq, 0);
    @(negedge clk); gie = 1;
    @(negedge clk);
    chk("R6 irq", irq, 1);
    pulse_ack();
    chk("R7 ack done", done, 0);
    chk("R7 ack irq", irq, 0);
    @(negedge clk); irq_en = 0; gie = 0;
  endtask

  task automatic t_fault();
    set_mode(1);
    @(negedge clk); ss_n = 0;
    tick_n(5);
    chk("R10 done", done, 1);
    chk("R10 mstr", mstr_st, 0);
    chk("R10 sck_oe", sck_oe, 0);
    @(negedge clk); ss_n = 1;
    tick_n(5);
    chk("R10 stays slave", mstr_st, 0);
    set_mode(1);
    chk("R10 re-master", mstr_st, 1);
    pulse_ack();
  endtask

  initial begin
    tick_n(3);
    rst_n = 1;
    tick_n(2);
    t_reset();
    m_xfer(0, 0, 0, 2'd0, 8'hA5, 8'h3C, 4);
    m_xfer(1, 0, 0, 2'd1, 8'h96, 8'hE1, 16);
    m_xfer(0, 1, 1, 2'd0, 8'h5A, 8'hC7, 2);
    m_xfer(1, 1, 1, 2'd2, 8'h01, 8'h80, 32);
    m_xfer(0, 0, 0, 2'd3, 8'hF0, 8'h0F, 128);
    m_xfer(0, 1, 0, 2'd2, 8'h6B, 8'h94, 64);
    m_xfer(1, 0, 1, 2'd1, 8'h33, 8'hCC, 8);
    m_xfer(0, 0, 1, 2'd3, 8'hE4, 8'h27, 64);
    t_collide();
    t_irq();
    t_fault();
    @(negedge clk); dbl = 0; rate = 0;
    s_xfer(0, 0, 1, 8'hB2, 8'h4D, 8'hB2, "R5 slave m0");
    s_xfer(1, 1, 1, 8'h3E, 8'hD1, 8'h3E, "R4 slave m3");
    // no reload: shift register holds 8'hD1, miso shows its top bit on select
    s_xfer(0, 0, 0, 8'h00, 8'h29, 8'hD1, "R11 slave echo");
    @(negedge clk); dbl = 1; rate = 2'd3;
    s_xfer(0, 0, 1, 8'hB2, 8'h4D, 8'hB2, "R12 slave rate");
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule